// File: doc/BRIEF.md
# Time-Slotted Serial Word Transmitter

This block is the sending half of a synchronous serial port that shares one data line among several devices by time-division multiplexing. A frame is cut into a fixed number of word-long time slots; a rising edge on the frame sync input marks slot 0. The whole block runs on the serial bit clock. The host side offers a word holding register, a "mute next slot" strobe, a transmit enable, an interrupt enable, a sticky underrun flag with a clear strobe, and an empty flag that asks for the next word at the start of every slot.

At every slot boundary the controller looks at what the host did during the slot that is ending. If the host wrote the mute strobe, the line is released for the whole next slot. If the host wrote a fresh word, that word goes out. If the host did nothing, an underrun is flagged and the word already held is sent again. The word goes out most significant bit first, one bit per clock, with a separate output enable that is high for exactly the bits of a driven slot. Dropping the enable never cuts a word short: it takes effect at the next boundary.

The controller is a four-state machine. `TX_IDLE` holds after reset until the first frame sync. At each boundary every state moves to one of three: `TX_OFF` when the enable is low (release), `TX_MUTE` when the mute strobe was seen (release), or `TX_SEND` otherwise (fresh load, or resend with underrun). Between boundaries the state holds.

Top module: `tdm_net_tx`

## Requirements
- R1: A `skip_wr` pulse seen during a slot makes the next slot undriven (`txd_oe` low for all of its bits), even if `data_wr` was also pulsed in the same slot. In that case the word written still replaces the held word.
- R2: If `data_wr` was pulsed during a slot and `skip_wr` was not, the next slot drives the held word on `txd`, MSB first, one bit per clock. `txd_oe` goes high in the clock cycle that follows the boundary edge and stays high for `WORD_W` cycles.
- R3: If neither strobe was pulsed during a slot while `tx_en` is high at the boundary, `urun_flag` is set at the boundary and the previously held word is driven again in the next slot.
- R4: `empty_flag` is set at every slot boundary. It clears on the clock after a `data_wr` or `skip_wr` pulse. `irq` equals `empty_flag` AND `irq_en`.
- R5: `urun_flag` stays set until a `urun_clr` pulse clears it. A new underrun in the same cycle as the clear wins.
- R6: With `tx_en` low at a boundary the next slot is undriven. Lowering or raising `tx_en` in the middle of a slot does not change that slot; the change applies from the next boundary.
- R7: Strobes inside a slot never change `txd` or `txd_oe` for the rest of that slot.
- R8: A rising edge of `fsync` is a boundary that starts slot 0 at its first bit, even in the middle of a slot. Without `fsync`, slots count `0..SLOTS-1` and wrap to 0. `slot_idx` shows the slot currently on the line.
- R9: After reset, and until the first `fsync` rising edge, `txd_oe`, `empty_flag`, `urun_flag` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame sync; a rising edge starts slot 0 |
| tx_en | input | 1 | Transmit enable, sampled at slot boundaries |
| irq_en | input | 1 | Enables `irq` from the empty flag |
| data_wr | input | 1 | One-cycle strobe that writes `data_in` to the holding register |
| data_in | input | WORD_W | Word to send |
| skip_wr | input | 1 | One-cycle strobe that mutes the next slot |
| urun_clr | input | 1 | One-cycle strobe that clears `urun_flag` |
| txd | output | 1 | Serial data, valid while `txd_oe` is high |
| txd_oe | output | 1 | Output enable for the shared data line |
| empty_flag | output | 1 | Request for the next slot's word |
| irq | output | 1 | Interrupt request |
| urun_flag | output | 1 | Sticky underrun status |
| slot_idx | output | SLOT_W | Index of the slot now on the line |

## Verification
Every cycle, the assertions check how the boundary decision maps to the line: mute leads to release, a fresh word is driven from its top bit, an empty slot sets the underrun flag and resends, and a low enable releases. They also check that the state holds between boundaries, the set and clear rules of both flags, the one-bit shift per clock, and that a frame sync restarts slot 0. Only the bench's scenarios can show that a whole word arrives in the right bit order across a slot. The same goes for a mid-slot enable change leaving the current word untouched, a short resynchronised slot, a wrap without frame sync, and the right word being resent after a chain of mutes and underruns.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    // Line state for the slot now on the wire
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,   // not yet framed
        TX_SEND = 2'd1,   // driving a word
        TX_MUTE = 2'd2,   // slot released by host request
        TX_OFF  = 2'd3    // slot released because transmit is disabled
    } tx_state_e;

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
    parameter int WORD_W = 8,
    parameter int SLOTS  = 5,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    output logic              boundary,
    output logic [SLOT_W-1:0] slot_idx
);

    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(WORD_W - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

    logic              fs_q;
    logic              synced_q;
    logic [BIT_W-1:0]  bit_q;
    logic [SLOT_W-1:0] slot_q;
    logic              fs_rise;
    logic              word_end;

    assign fs_rise  = fsync & ~fs_q;
    assign word_end = synced_q && (bit_q == BIT_LAST);
    assign boundary = fs_rise | word_end;
    assign slot_idx = slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q     <= 1'b0;
            synced_q <= 1'b0;
            bit_q    <= '0;
            slot_q   <= '0;
        end else begin
            fs_q <= fsync;
            if (fs_rise) begin
                synced_q <= 1'b1;
                bit_q    <= '0;
                slot_q   <= '0;
            end else if (word_end) begin
                bit_q  <= '0;
                slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + SLOT_W'(1);
            end else if (synced_q) begin
                bit_q <= bit_q + BIT_W'(1);
            end
        end
    end

    // R8: frame sync restarts slot 0 at bit 0
    assert_fs_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fs_rise |=> (slot_q == '0) && (bit_q == '0));

    // R8: last slot wraps to slot 0 without frame sync
    assert_slot_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && !fs_rise && slot_q == SLOT_LAST) |=> (slot_q == '0));

endmodule

// File: rtl/tdm_tx_hostif.sv
module tdm_tx_hostif #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [WORD_W-1:0] data_in,
    input  logic              skip_wr,
    input  logic              urun_clr,
    input  logic              boundary,
    input  logic              urun_set,
    output logic [WORD_W-1:0] hold_q,
    output logic              data_pend,
    output logic              skip_pend,
    output logic              empty_flag,
    output logic              urun_flag
);

    logic any_wr;
    assign any_wr = data_wr | skip_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (data_wr) begin
            hold_q <= data_in;
        end
    end

    // Pending strobes cover the slot being sent; a boundary starts a new window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_pend  <= 1'b0;
            skip_pend  <= 1'b0;
            empty_flag <= 1'b0;
        end else if (boundary) begin
            data_pend  <= data_wr;
            skip_pend  <= skip_wr;
            empty_flag <= ~any_wr;
        end else begin
            data_pend  <= data_pend | data_wr;
            skip_pend  <= skip_pend | skip_wr;
            if (any_wr) begin
                empty_flag <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            urun_flag <= 1'b0;
        end else if (urun_set) begin
            urun_flag <= 1'b1;
        end else if (urun_clr) begin
            urun_flag <= 1'b0;
        end
    end

    assert_empty_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !any_wr) |=> empty_flag);

    assert_empty_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr |=> !empty_flag);

    assert_urun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (urun_flag && !urun_clr) |=> urun_flag);

    assert_urun_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        urun_set |=> urun_flag);

endmodule

// File: rtl/tdm_tx_shifter.sv
module tdm_tx_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    output logic              msb
);

    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_val;
        end else begin
            sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    assign msb = sh_q[WORD_W-1];

    // R2: one bit per clock, MSB first
    assert_shift_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (sh_q == {$past(sh_q[WORD_W-2:0]), 1'b0}));

endmodule

// File: rtl/tdm_net_tx.sv
module tdm_net_tx
    import tdm_tx_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int SLOTS  = 5,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              tx_en,
    input  logic              irq_en,
    input  logic              data_wr,
    input  logic [WORD_W-1:0] data_in,
    input  logic              skip_wr,
    input  logic              urun_clr,
    output logic              txd,
    output logic              txd_oe,
    output logic              empty_flag,
    output logic              irq,
    output logic              urun_flag,
    output logic [SLOT_W-1:0] slot_idx
);

    tx_state_e         state_q;
    tx_state_e         state_d;
    logic              boundary;
    logic              load;
    logic              urun_set;
    logic              data_pend;
    logic              skip_pend;
    logic [WORD_W-1:0] hold_q;
    logic              sh_msb;

    tdm_slot_timer #(.WORD_W(WORD_W), .SLOTS(SLOTS)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .boundary (boundary),
        .slot_idx (slot_idx)
    );

    tdm_tx_hostif #(.WORD_W(WORD_W)) host_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_wr    (data_wr),
        .data_in    (data_in),
        .skip_wr    (skip_wr),
        .urun_clr   (urun_clr),
        .boundary   (boundary),
        .urun_set   (urun_set),
        .hold_q     (hold_q),
        .data_pend  (data_pend),
        .skip_pend  (skip_pend),
        .empty_flag (empty_flag),
        .urun_flag  (urun_flag)
    );

    tdm_tx_shifter #(.WORD_W(WORD_W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (hold_q),
        .msb      (sh_msb)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Boundary decision: every state takes the same three-way choice
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        urun_set = 1'b0;
        unique case (state_q)
            TX_IDLE, TX_SEND, TX_MUTE, TX_OFF: begin
                if (boundary) begin
                    if (!tx_en) begin
                        state_d = TX_OFF;
                    end else if (skip_pend) begin
                        state_d = TX_MUTE;
                    end else begin
                        state_d  = TX_SEND;
                        load     = 1'b1;
                        urun_set = ~data_pend;
                    end
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // Line outputs
    always_comb begin
        txd_oe = 1'b0;
        txd    = 1'b0;
        unique case (state_q)
            TX_SEND: begin
                txd_oe = 1'b1;
                txd    = sh_msb;
            end
            default: begin
                txd_oe = 1'b0;
                txd    = 1'b0;
            end
        endcase
    end

    assign irq = empty_flag & irq_en;

    assert_mute_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && tx_en && skip_pend) |=> !txd_oe);

    assert_fresh_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && tx_en && !skip_pend && data_pend)
            |=> (txd_oe && txd == $past(hold_q[WORD_W-1])));

    assert_underrun_resend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && tx_en && !skip_pend && !data_pend) |=> (urun_flag && txd_oe));

    assert_disabled_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !tx_en) |=> !txd_oe);

    assert_state_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(state_q));

endmodule

// File: tb/tdm_net_tx_tb_top.sv
module tdm_net_tx_tb_top;

    localparam int W  = 8;
    localparam int S  = 5;
    localparam int SW = (S > 1) ? $clog2(S) : 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fsync = 1'b0;
    logic          tx_en = 1'b0;
    logic          irq_en = 1'b0;
    logic          data_wr = 1'b0;
    logic [W-1:0]  data_in = '0;
    logic          skip_wr = 1'b0;
    logic          urun_clr = 1'b0;
    logic          txd;
    logic          txd_oe;
    logic          empty_flag;
    logic          irq;
    logic          urun_flag;
    logic [SW-1:0] slot_idx;

    tdm_net_tx #(.WORD_W(W), .SLOTS(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .tx_en(tx_en), .irq_en(irq_en),
        .data_wr(data_wr), .data_in(data_in), .skip_wr(skip_wr), .urun_clr(urun_clr),
        .txd(txd), .txd_oe(txd_oe), .empty_flag(empty_flag), .irq(irq),
        .urun_flag(urun_flag), .slot_idx(slot_idx)
    );

    always #5 clk = ~clk;

    int     checks = 0;
    int     errors = 0;
    bit     done = 1'b0;

    // Bench model
    logic [W-1:0] m_hold = '0;
    logic [W-1:0] exp_word = '0;
    bit           exp_oe = 1'b0;
    bit           m_urun = 1'b0;
    int           exp_slot = 0;
    string        exp_tag = "R2";

    task automatic chk_eq(input string req, input string what,
                          input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int next_slot(input int cur, input bit fs);
        return fs ? 0 : ((cur + 1) % S);
    endfunction

    // act bit0 = data write, bit1 = mute write
    task automatic run_slot(input int len, input int act, input logic [W-1:0] val,
                            input bit en_next, input bit clr, input bit fs_end, input bit ien);
        int ab;
        ab = (len >= 8) ? 2 : 1;
        for (int b = 0; b < len; b++) begin
            @(negedge clk);
            if (b == 0) begin
                fsync = 1'b0;
                chk_eq("R8", "slot_idx", slot_idx, exp_slot);
                chk_eq("R4", "empty at boundary", empty_flag, 1);
                chk_eq("R4", "irq at boundary", irq, irq_en);
                chk_eq(m_urun ? "R3" : "R5", "urun_flag", urun_flag, m_urun);
            end
            begin
                string tg;
                tg = (b == ab + 1) ? "R7" : ((b == 4 && len >= 8) ? "R6" : exp_tag);
                chk_eq(tg, "txd_oe", txd_oe, exp_oe);
                if (exp_oe) chk_eq(tg, "txd bit", txd, exp_word[W-1-b]);
            end
            if (b == ab + 1) begin
                data_wr = 1'b0;
                skip_wr = 1'b0;
                chk_eq("R4", "empty after strobe", empty_flag, (act == 0) ? 1 : 0);
                chk_eq("R4", "irq after strobe", irq, (act == 0) ? irq_en : 0);
            end
            if (b == ab) begin
                data_wr = act[0];
                skip_wr = act[1];
                data_in = val;
                if (act[0]) m_hold = val;
            end
            if (b == 3 && len >= 8) tx_en = en_next;
            if (b == 4 && len >= 8 && clr) urun_clr = 1'b1;
            if (b == 5 && len >= 8 && clr) begin
                urun_clr = 1'b0;
                chk_eq("R5", "urun after clear", urun_flag, 0);
                m_urun = 1'b0;
            end
            if (b == len - 1) begin
                fsync  = fs_end;
                irq_en = ien;
                if (len < 8) tx_en = en_next;
            end
        end
        exp_slot = next_slot(exp_slot, fs_end);
        if (!en_next) begin
            exp_oe = 1'b0; exp_tag = "R6";
        end else if (act[1]) begin
            exp_oe = 1'b0; exp_tag = "R1";
        end else if (act[0]) begin
            exp_oe = 1'b1; exp_word = m_hold; exp_tag = "R2";
        end else begin
            exp_oe = 1'b1; exp_word = m_hold; exp_tag = "R3"; m_urun = 1'b1;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        chk_eq("R9", "oe in reset", txd_oe, 0);
        chk_eq("R9", "empty in reset", empty_flag, 0);
        rst_n = 1'b1;
        tx_en = 1'b1;
        irq_en = 1'b1;
        repeat (12) begin
            @(negedge clk);
            chk_eq("R9", "oe before sync", txd_oe, 0);
            chk_eq("R9", "empty before sync", empty_flag, 0);
            chk_eq("R9", "urun before sync", urun_flag, 0);
            chk_eq("R9", "irq before sync", irq, 0);
        end
        // preload a word, then start the first frame
        data_wr = 1'b1; data_in = 8'hA5; m_hold = 8'hA5;
        @(negedge clk);
        data_wr = 1'b0;
        fsync = 1'b1;
        exp_slot = 0; exp_oe = 1'b1; exp_word = 8'hA5; exp_tag = "R2";

        // directed corner cases
        run_slot(8, 1, 8'h3C, 1, 0, 0, 0);  // slot0 -> slot1 fresh
        run_slot(8, 2, 8'h00, 1, 0, 0, 0);  // slot1 -> slot2 muted
        run_slot(8, 3, 8'h81, 1, 0, 0, 0);  // both strobes: mute wins
        run_slot(8, 0, 8'h00, 1, 0, 0, 1);  // nothing: underrun resend 81
        run_slot(8, 1, 8'h5A, 1, 1, 1, 1);  // clear urun, frame sync
        run_slot(8, 1, 8'h11, 0, 0, 0, 0);  // disable mid-slot
        run_slot(8, 1, 8'h22, 1, 0, 0, 0);  // disabled slot, re-enable
        run_slot(8, 0, 8'h00, 1, 0, 0, 0);  // underrun resend 22
        run_slot(3, 1, 8'h33, 1, 0, 1, 0);  // short slot, early resync
        for (int k = 0; k < S; k++) run_slot(8, 1, 8'(8'h40 + k), 1, 0, 0, 0); // wrap, no sync

        // constrained random
        for (int n = 0; n < 70; n++) begin
            int r;
            int a;
            r = int'($urandom % 8);
            a = (r < 1) ? 0 : (r < 4) ? 1 : (r < 6) ? 2 : 3;
            run_slot(8, a, 8'($urandom), ($urandom % 6) != 0, ($urandom % 3) == 0,
                     (exp_slot == S - 1) && (($urandom % 4) != 0), 1'($urandom));
        end
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule